// File: doc/BRIEF.md
# SCSI Adapter DMA Control Block with Interrupt Gating

This block is the register-mapped control and status logic of a SCSI host adapter's DMA engine. It sits between a 16-bit host register port and an external SCSI protocol controller. It holds a control/status word, a 32-bit DMA address, a 32-bit DMA count, a 32-bit FIFO residual count and an interrupt vector/address-modifier word. A host bus master outside the block performs the transfers and reports each byte moved. The block counts the residual down as those bytes move.

The request from the protocol controller is passed to the host only while DMA is enabled and the FIFO residual count is zero. While DMA is enabled, the host may not reach the protocol controller. Any access to the controller's window in that state is blocked and recorded as a sticky conflict. A bus error reported during DMA is also recorded. Either error raises the DMA interrupt indication. Clearing DMA enable freezes all counters, so the host can read back how much remains.

Top module: `scsi_dma_gate`

## Requirements
- R1: After reset, every control bit is 0, so both reset outputs `fifoRstN` and `scsiRstN` are low (asserted). All counters are 0 and `hostIrq` is 0.
- R2: The host decodes a 2 KB window (`regAddr`, byte address, bit 0 ignored). Adapter words are at 0x010 control/status, 0x012/0x014 DMA address high/low, 0x016/0x018 DMA count high/low, 0x01A/0x01C FIFO residual high/low, and 0x01E vector word. Each word reads back what was written, and `dmaAddr`/`dmaCount` show the 32-bit values.
- R3: Control/status bit 0 is DMA enable. Bit 1 is direction (1 = send, memory to SCSI; 0 = receive) and drives `sendDir`. Bit 2 is FIFO reset and bit 3 is SCSI reset; both are active low and drive `fifoRstN`/`scsiRstN`. Bits 3:0 read back as written.
- R4: The vector word holds the interrupt vector in bits 7:0 and the bus address modifier in bits 15:8.
- R5: `ctlIrq` reaches `hostIrq` only while DMA enable is 1 and the FIFO residual is zero. Control/status bit 8 always shows the raw `ctlIrq`.
- R6: While DMA enable is 0, an access to 0x000–0x00F asserts `ctlSel`, and a read there returns `ctlRdata`. While DMA enable is 1, such an access leaves `ctlSel` low and reads 0. It also sets the sticky conflict bit 10, which is cleared by writing 1 to bit 10.
- R7: Each `byteXfer` cycle with DMA enable 1, FIFO reset released and a nonzero residual does three things: the residual drops by 1, the DMA count drops by 1 and the DMA address rises by 1. When the residual reaches 0, the sticky done flag is set.
- R8: While DMA enable is 0, `byteXfer` leaves all counters unchanged.
- R9: `busErr` while DMA enable is 1 sets the sticky bus-error bit 11, cleared by writing 1 to bit 11. A set done flag, bit 10 or bit 11 shows as DMA-interrupt-pending bit 9 and drives `hostIrq` high.
- R10: While FIFO reset is asserted (bit 2 = 0), the residual count is held at 0 and writes to it are ignored.
- R11: Writing 1 to bit 9 clears the done flag, and so does a write to either residual half. Writes to addresses other than 0x000–0x01F are ignored, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 11 | Host register byte address within the 2 KB window |
| regWr | input | 1 | Host write strobe |
| regRd | input | 1 | Host read strobe |
| regWdata | input | 16 | Host write data |
| regRdata | output | 16 | Host read data |
| ctlSel | output | 1 | Forwarded access strobe to the protocol controller |
| ctlRdata | input | 16 | Read data from the protocol controller |
| ctlIrq | input | 1 | Protocol controller interrupt request |
| hostIrq | output | 1 | Interrupt to the host |
| byteXfer | input | 1 | One byte moved by the bus master this cycle |
| busErr | input | 1 | Bus error from the bus master |
| dmaEn | output | 1 | DMA enable |
| sendDir | output | 1 | Transfer direction, 1 = send |
| fifoRstN | output | 1 | Active-low FIFO reset |
| scsiRstN | output | 1 | Active-low SCSI reset |
| dmaAddr | output | 32 | Current DMA address |
| dmaCount | output | 32 | Current DMA count |

## Verification
The hardest situation to reach is the one where the controller request is pending but is held off by a nonzero residual while DMA is enabled. Reaching it needs a precise order of steps. First the resets are released, then DMA is enabled with a zero residual, and `ctlIrq` is shown to pass. Then a residual is written and the request is shown to be held off, and writing zero shows it passes again. The conflict path is reached in a similar way: DMA is enabled, the controller window is read, and the test checks that the strobe stayed low and that the sticky bit and the interrupt appear.

// File: rtl/scsi_dma_gate_pkg.sv
package scsi_dma_gate_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrAddrHi;
    logic wrAddrLo;
    logic wrCntHi;
    logic wrCntLo;
    logic wrFifoHi;
    logic wrFifoLo;
    logic wrIvAm;
    logic countEn;
    logic fifoClr;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    IDX_CSR   = 3'd0,
    IDX_ADDRH = 3'd1,
    IDX_ADDRL = 3'd2,
    IDX_CNTH  = 3'd3,
    IDX_CNTL  = 3'd4,
    IDX_FIFOH = 3'd5,
    IDX_FIFOL = 3'd6,
    IDX_IVAM  = 3'd7
  } regIdx_t;
endpackage

// File: rtl/scsi_dma_gate_dp.sv
module scsi_dma_gate_dp
  import scsi_dma_gate_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [REG_W-1:0]   wdata,
  output logic [2*REG_W-1:0] addrQ,
  output logic [2*REG_W-1:0] cntQ,
  output logic [2*REG_W-1:0] fifoQ,
  output logic [REG_W-1:0]   ivAmQ,
  output logic               fifoZero,
  output logic               fifoHitZero
);
  localparam int CNT_W = 2 * REG_W;

  logic fifoWr;
  assign fifoWr = stb.wrFifoHi | stb.wrFifoLo;
  assign fifoZero = (fifoQ == '0);
  assign fifoHitZero = stb.countEn && !fifoWr && (fifoQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '0;
      fifoQ <= '0;
      ivAmQ <= '0;
    end else begin
      if (stb.wrAddrHi)      addrQ[CNT_W-1:REG_W] <= wdata;
      else if (stb.wrAddrLo) addrQ[REG_W-1:0]     <= wdata;
      else if (stb.countEn)  addrQ <= addrQ + CNT_W'(1);

      if (stb.wrCntHi)      cntQ[CNT_W-1:REG_W] <= wdata;
      else if (stb.wrCntLo) cntQ[REG_W-1:0]     <= wdata;
      else if (stb.countEn) cntQ <= cntQ - CNT_W'(1);

      if (stb.fifoClr)       fifoQ <= '0;
      else if (stb.wrFifoHi) fifoQ[CNT_W-1:REG_W] <= wdata;
      else if (stb.wrFifoLo) fifoQ[REG_W-1:0]     <= wdata;
      else if (stb.countEn)  fifoQ <= fifoQ - CNT_W'(1);

      if (stb.wrIvAm) ivAmQ <= wdata;
    end
  end

  // R7
  fifo_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && !fifoWr && !stb.fifoClr) |=> (fifoQ == $past(fifoQ) - CNT_W'(1)));

  // R10
  fifo_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fifoClr |=> (fifoQ == '0));
endmodule

// File: rtl/scsi_dma_gate_ctrl.sv
module scsi_dma_gate_ctrl
  import scsi_dma_gate_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:1]  wordAddr,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [3:0]         ctrlBitsIn,
  input  logic [2:0]         clrBitsIn,
  input  logic               ctlIrq,
  input  logic [REG_W-1:0]   ctlRdata,
  input  logic               byteXfer,
  input  logic               busErr,
  input  logic [2*REG_W-1:0] dpAddr,
  input  logic [2*REG_W-1:0] dpCnt,
  input  logic [2*REG_W-1:0] dpFifo,
  input  logic [REG_W-1:0]   dpIvAm,
  input  logic               fifoZero,
  input  logic               fifoHitZero,
  output dpStrobe_t          stb,
  output logic [REG_W-1:0]   regRdata,
  output logic               ctlSel,
  output logic               hostIrq,
  output logic [3:0]         ctrlQ
);
  localparam int CNT_W = 2 * REG_W;

  logic inCtlWin, inAdpWin, access, blocked, csrWr;
  logic conflictQ, busErrQ, doneQ, dmaIrqPend, dmaEnQ, fifoRstNQ;
  regIdx_t idx;

  assign idx      = regIdx_t'(wordAddr[3:1]);
  assign inCtlWin = (wordAddr[ADDR_W-1:4] == '0);
  assign inAdpWin = (wordAddr[ADDR_W-1:4] == (ADDR_W-4)'(1));
  assign access   = regWr | regRd;
  assign dmaEnQ   = ctrlQ[0];
  assign fifoRstNQ = ctrlQ[2];
  assign blocked  = access && inCtlWin && dmaEnQ;
  assign ctlSel   = access && inCtlWin && !dmaEnQ;
  assign csrWr    = regWr && inAdpWin && (idx == IDX_CSR);

  always_comb begin
    stb = '0;
    if (regWr && inAdpWin) begin
      stb.wrAddrHi = (idx == IDX_ADDRH);
      stb.wrAddrLo = (idx == IDX_ADDRL);
      stb.wrCntHi  = (idx == IDX_CNTH);
      stb.wrCntLo  = (idx == IDX_CNTL);
      stb.wrFifoHi = (idx == IDX_FIFOH);
      stb.wrFifoLo = (idx == IDX_FIFOL);
      stb.wrIvAm   = (idx == IDX_IVAM);
    end
    stb.fifoClr = !fifoRstNQ;
    stb.countEn = byteXfer && dmaEnQ && fifoRstNQ && !fifoZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      conflictQ <= 1'b0;
      busErrQ   <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      if (csrWr) ctrlQ <= ctrlBitsIn;

      if (blocked)                  conflictQ <= 1'b1;
      else if (csrWr && clrBitsIn[1]) conflictQ <= 1'b0;

      if (busErr && dmaEnQ)          busErrQ <= 1'b1;
      else if (csrWr && clrBitsIn[2]) busErrQ <= 1'b0;

      if (fifoHitZero) doneQ <= 1'b1;
      else if ((csrWr && clrBitsIn[0]) || stb.wrFifoHi || stb.wrFifoLo || !fifoRstNQ)
        doneQ <= 1'b0;
    end
  end

  assign dmaIrqPend = doneQ | conflictQ | busErrQ;
  assign hostIrq    = dmaIrqPend | (dmaEnQ & ctlIrq & fifoZero);

  always_comb begin
    regRdata = '0;
    if (inCtlWin) begin
      regRdata = dmaEnQ ? '0 : ctlRdata;
    end else if (inAdpWin) begin
      unique case (idx)
        IDX_CSR:   regRdata = REG_W'({busErrQ, conflictQ, dmaIrqPend, ctlIrq, 4'b0000, ctrlQ});
        IDX_ADDRH: regRdata = dpAddr[CNT_W-1:REG_W];
        IDX_ADDRL: regRdata = dpAddr[REG_W-1:0];
        IDX_CNTH:  regRdata = dpCnt[CNT_W-1:REG_W];
        IDX_CNTL:  regRdata = dpCnt[REG_W-1:0];
        IDX_FIFOH: regRdata = dpFifo[CNT_W-1:REG_W];
        IDX_FIFOL: regRdata = dpFifo[REG_W-1:0];
        IDX_IVAM:  regRdata = dpIvAm;
        default:   regRdata = '0;
      endcase
    end
  end

  // R6
  conflict_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (access && inCtlWin && dmaEnQ) |=> conflictQ);

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaEnQ && !stb.wrFifoHi && !stb.wrFifoLo && fifoRstNQ) |=> $stable(dpFifo));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq && !dmaIrqPend) |-> (dmaEnQ && fifoZero && ctlIrq));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busErrQ && !(csrWr && clrBitsIn[2])) |=> busErrQ);
endmodule

// File: rtl/scsi_dma_gate.sv
module scsi_dma_gate
  import scsi_dma_gate_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  output logic                ctlSel,
  input  logic [REG_W-1:0]    ctlRdata,
  input  logic                ctlIrq,
  output logic                hostIrq,
  input  logic                byteXfer,
  input  logic                busErr,
  output logic                dmaEn,
  output logic                sendDir,
  output logic                fifoRstN,
  output logic                scsiRstN,
  output logic [2*REG_W-1:0]  dmaAddr,
  output logic [2*REG_W-1:0]  dmaCount
);
  localparam int CNT_W = 2 * REG_W;

  dpStrobe_t        stb;
  logic [CNT_W-1:0] fifoQ;
  logic [REG_W-1:0] ivAmQ;
  logic             fifoZero, fifoHitZero;
  logic [3:0]       ctrlQ;

  scsi_dma_gate_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wordAddr(regAddr[ADDR_W-1:1]), .regWr(regWr), .regRd(regRd),
    .ctrlBitsIn(regWdata[3:0]), .clrBitsIn(regWdata[11:9]),
    .ctlIrq(ctlIrq), .ctlRdata(ctlRdata), .byteXfer(byteXfer), .busErr(busErr),
    .dpAddr(dmaAddr), .dpCnt(dmaCount), .dpFifo(fifoQ), .dpIvAm(ivAmQ),
    .fifoZero(fifoZero), .fifoHitZero(fifoHitZero),
    .stb(stb), .regRdata(regRdata), .ctlSel(ctlSel), .hostIrq(hostIrq),
    .ctrlQ(ctrlQ)
  );

  scsi_dma_gate_dp #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(regWdata),
    .addrQ(dmaAddr), .cntQ(dmaCount), .fifoQ(fifoQ), .ivAmQ(ivAmQ),
    .fifoZero(fifoZero), .fifoHitZero(fifoHitZero)
  );

  assign dmaEn    = ctrlQ[0];
  assign sendDir  = ctrlQ[1];
  assign fifoRstN = ctrlQ[2];
  assign scsiRstN = ctrlQ[3];
endmodule

// File: tb/scsi_dma_gate_tb.sv
`timescale 1ns/1ps
module scsi_dma_gate_tb;
  localparam logic [10:0] A_CSR = 11'h010, A_AH = 11'h012, A_AL = 11'h014,
                          A_CH = 11'h016, A_CL = 11'h018, A_FH = 11'h01A,
                          A_FL = 11'h01C, A_IV = 11'h01E;

  logic clk = 0, rstN = 0;
  logic [10:0] regAddr = '0;
  logic regWr = 0, regRd = 0, ctlIrq = 0, byteXfer = 0, busErr = 0;
  logic [15:0] regWdata = '0, ctlRdata = '0, regRdata;
  logic ctlSel, hostIrq, dmaEn, sendDir, fifoRstN, scsiRstN;
  logic [31:0] dmaAddr, dmaCount;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scsi_dma_gate u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .ctlSel(ctlSel), .ctlRdata(ctlRdata),
    .ctlIrq(ctlIrq), .hostIrq(hostIrq), .byteXfer(byteXfer), .busErr(busErr),
    .dmaEn(dmaEn), .sendDir(sendDir), .fifoRstN(fifoRstN), .scsiRstN(scsiRstN),
    .dmaAddr(dmaAddr), .dmaCount(dmaCount)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [15:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rd(logic [10:0] a, output logic [15:0] d, output logic sel);
    @(negedge clk); regAddr = a; regRd = 1; #1; d = regRdata; sel = ctlSel;
    @(negedge clk); regRd = 0;
  endtask

  task automatic pulseXfer();
    @(negedge clk); byteXfer = 1; @(negedge clk); byteXfer = 0;
  endtask

  task automatic idle();
    wr(A_CSR, 16'h0E0C); wr(A_FH, 0); wr(A_FL, 0);
  endtask

  task automatic t_reset();
    logic [15:0] d; logic s;
    rd(A_CSR, d, s);
    chk("R1 csr", d, 0);
    chk("R1 rst pins", {fifoRstN, scsiRstN}, 0);
    chk("R1 irq", hostIrq, 0);
    chk("R1 addr", dmaAddr, 0);
    chk("R1 count", dmaCount, 0);
  endtask

  task automatic t_regs();
    logic [15:0] d; logic s;
    wr(A_CSR, 16'h000E);
    chk("R3 sendDir", sendDir, 1);
    chk("R3 rst released", {fifoRstN, scsiRstN, dmaEn}, 3'b110);
    rd(A_CSR, d, s); chk("R3 csr readback", d, 16'h000E);
    wr(A_CSR, 16'h000C);
    chk("R3 receive dir", sendDir, 0);
    wr(A_AH, 16'h1234); wr(A_AL, 16'h5678);
    chk("R2 dmaAddr", dmaAddr, 32'h12345678);
    wr(A_CH, 16'h0001); wr(A_CL, 16'h0002);
    chk("R2 dmaCount", dmaCount, 32'h00010002);
    rd(A_AH, d, s); chk("R2 addr hi", d, 16'h1234);
    rd(A_CL, d, s); chk("R2 cnt lo", d, 16'h0002);
    wr(A_IV, 16'h3D5A);
    rd(A_IV, d, s);
    chk("R4 vector", d[7:0], 8'h5A);
    chk("R4 modifier", d[15:8], 8'h3D);
    wr(11'h100, 16'hFFFF); wr(11'h020, 16'hBEEF);
    rd(11'h100, d, s); chk("R11 outside read", d, 0);
    chk("R11 outside write", dmaAddr, 32'h12345678);
    chk("R11 csr unchanged", {fifoRstN, scsiRstN, dmaEn}, 3'b110);
  endtask

  task automatic t_count();
    logic [15:0] d; logic s;
    idle();
    wr(A_AH, 0); wr(A_AL, 16'h0100); wr(A_CH, 0); wr(A_CL, 16'd10);
    wr(A_FL, 16'd3); wr(A_CSR, 16'h000D);
    chk("R7 irq held before done", hostIrq, 0);
    repeat (3) pulseXfer();
    rd(A_FL, d, s); chk("R7 fifo zero", d, 0);
    chk("R7 count", dmaCount, 32'd7);
    chk("R7 addr", dmaAddr, 32'h103);
    rd(A_CSR, d, s); chk("R9 done pending", d, 16'h020D);
    chk("R7 done irq", hostIrq, 1);
    pulseXfer();
    chk("R7 no count at zero", dmaCount, 32'd7);
    wr(A_CSR, 16'h020D);
    chk("R11 done cleared", hostIrq, 0);
  endtask

  task automatic t_freeze();
    logic [15:0] d; logic s;
    idle();
    wr(A_FL, 16'd4);
    pulseXfer(); pulseXfer();
    rd(A_FL, d, s); chk("R8 fifo frozen", d, 16'd4);
    chk("R8 addr frozen", dmaAddr, 32'h103);
  endtask

  task automatic t_gate();
    logic [15:0] d; logic s;
    idle();
    @(negedge clk); ctlIrq = 1; #1;
    chk("R5 gated when disabled", hostIrq, 0);
    wr(A_CSR, 16'h000D); #1;
    chk("R5 passes enabled", hostIrq, 1);
    wr(A_FL, 16'd5); #1;
    chk("R5 held by residual", hostIrq, 0);
    wr(A_FL, 16'd0); #1;
    chk("R5 passes again", hostIrq, 1);
    rd(A_CSR, d, s); chk("R5 raw bit", d, 16'h010D);
    @(negedge clk); ctlIrq = 0;
    wr(A_CSR, 16'h000C);
  endtask

  task automatic t_conflict();
    logic [15:0] d; logic s;
    idle();
    ctlRdata = 16'hA5C3;
    wr(A_CSR, 16'h000D);
    rd(11'h006, d, s);
    chk("R6 blocked read", d, 0);
    chk("R6 blocked sel", s, 0);
    rd(A_CSR, d, s); chk("R6 conflict sticky", d, 16'h060D);
    chk("R9 conflict irq", hostIrq, 1);
    wr(A_CSR, 16'h040D);
    rd(A_CSR, d, s); chk("R6 conflict cleared", d, 16'h000D);
    wr(A_CSR, 16'h000C);
    rd(11'h006, d, s);
    chk("R6 forwarded read", d, 16'hA5C3);
    chk("R6 forwarded sel", s, 1);
    rd(A_CSR, d, s); chk("R6 no conflict", d, 16'h000C);
  endtask

  task automatic t_buserr();
    logic [15:0] d; logic s;
    idle();
    @(negedge clk); busErr = 1; @(negedge clk); busErr = 0;
    rd(A_CSR, d, s); chk("R9 ignored when disabled", d, 16'h000C);
    wr(A_CSR, 16'h000D);
    @(negedge clk); busErr = 1; @(negedge clk); busErr = 0;
    rd(A_CSR, d, s); chk("R9 bus error sticky", d, 16'h0A0D);
    chk("R9 bus error irq", hostIrq, 1);
    wr(A_CSR, 16'h080D);
    rd(A_CSR, d, s); chk("R9 bus error cleared", d, 16'h000D);
    wr(A_CSR, 16'h000C);
  endtask

  task automatic t_fiforst();
    logic [15:0] d; logic s;
    idle();
    wr(A_FL, 16'd4);
    wr(A_CSR, 16'h0008);
    chk("R3 fifo reset pin", fifoRstN, 0);
    rd(A_FL, d, s); chk("R10 fifo cleared", d, 0);
    wr(A_FL, 16'd7);
    rd(A_FL, d, s); chk("R10 write ignored", d, 0);
    wr(A_CSR, 16'h000C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_count();
    t_freeze();
    t_gate();
    t_conflict();
    t_buserr();
    t_fiforst();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule